// File: doc/BRIEF.md
# Cascadable Binary CAM with Match, Multiple-Match and Full Flags

This block is a small binary content-addressable store of 64-bit words, each with a validity bit. A 64-bit key is compared against every valid word in one cycle. An optional per-bit mask takes any chosen bit positions out of the comparison. The compare result is held in a match latch. A priority encoder reports the lowest-index matching word. A second encoder reports the lowest-index empty word, which is the target of a write-to-next-free operation. Words are filled by index or at the next free slot. They are emptied by index or by an associative match against the key and mask.

The three flags are active low. They are qualified by two cascade inputs that come from a device of higher priority, so that several copies can be chained into one larger table. A device's match flag feeds the next device's match input, and its full flag feeds the next device's full input. In a single-device system, tie `match_in_n` high and `full_in_n` low. All operations take effect on the rising clock edge. The cascade qualification is combinational from the registered local state. The reset input is asynchronous and active low, and it is released through a two-stage synchronizer.

Top module: `cam_match_top`

## Requirements
- R1: After reset every word is invalid, `match_n`, `multi_n` and `full_n` are high, `free_addr` is 0 and `hit_addr` is all ones.
- R2: A compare (`op`=5, `sel` high) marks a word as hit when it is valid and equals `key` on every bit where `mask` is 0; a `mask` bit of 1 excludes that bit position.
- R3: `match_n` is low when the match latch holds at least one hit or when `match_in_n` is low; with `match_in_n` high it reflects only local hits.
- R4: With `match_in_n` high, `multi_n` is low only when two or more words are in the match latch; with `match_in_n` low, it is low when one or more are.
- R5: `full_n` is low only when every local word is valid and `full_in_n` is low; with `full_in_n` high it stays high.
- R6: `hit_addr` is the lowest index in the match latch, or all ones when the latch is empty (`match_n` tells the two cases apart).
- R7: Operations other than compare and advance (`op` 0 to 4) leave the match latch, `match_n`, `multi_n` and `hit_addr` unchanged.
- R8: A compare with `sel` low clears the match latch, so that the device reports a mismatch.
- R9: Advance (`op`=6, `sel` high) removes the lowest-index entry from the match latch, so that the next matching word becomes `hit_addr`.
- R10: A write by index (`op`=1) stores `key` at `idx` and sets that word valid; an invalidate by index (`op`=3) clears the validity of word `idx`.
- R11: A write to next free (`op`=2) stores `key` at `free_addr` and sets it valid, but only when `full_in_n` is low and a local word is empty; otherwise nothing changes. `free_addr` is the lowest-index invalid word.
- R12: An invalidate by match (`op`=4) clears the validity of every word that the compare rule of R2 hits for the current `key` and `mask`.
- R13: With `sel` low, the operations 1 to 4 and 6 change no word, validity bit or match entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Device select for the current operation |
| op | input | 3 | Operation: 0 idle, 1 write index, 2 write next free, 3 invalidate index, 4 invalidate match, 5 compare, 6 advance |
| idx | input | 4 | Word index for operations 1 and 3 |
| key | input | 64 | Comparand, and write data |
| mask | input | 64 | Compare mask; a 1 excludes that bit |
| match_in_n | input | 1 | Match flag from the higher-priority device |
| full_in_n | input | 1 | Full flag from the higher-priority device |
| match_n | output | 1 | Cascaded match flag, active low |
| multi_n | output | 1 | Multiple-match flag, active low |
| full_n | output | 1 | Cascaded full flag, active low |
| hit_addr | output | 4 | Lowest-index matching word |
| free_addr | output | 4 | Lowest-index empty word |

## Verification
On every cycle, the assertions check the following: a low multiple-match flag always comes with a low match flag; a deselected compare empties the match latch; idle, write and invalidate operations leave the latch unchanged; advance removes exactly one entry; a write to next free into a full array changes no validity bit; and `free_addr` always names an empty word. Some behaviour can only be shown through the bench's scenarios against its reference model. This covers the masked comparison result, the lowest-index choice of `hit_addr` and `free_addr`, stored data that is later found again by compare, invalidate-by-match, and the cascade qualification under both levels of each cascade input.

// File: rtl/cam_match_pkg.sv
package cam_match_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_WR_IDX  = 3'd1,
    OP_WR_FREE = 3'd2,
    OP_CLR_IDX = 3'd3,
    OP_CLR_HIT = 3'd4,
    OP_CMP     = 3'd5,
    OP_ADV     = 3'd6
  } cam_op_e;
endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_idx,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic [DEPTH-1:0]             clr_vec,
  output logic [DEPTH-1:0][WIDTH-1:0]  words,
  output logic [DEPTH-1:0]             valid
);
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] valid_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [WIDTH-1:0] row_q;
    logic             row_we;
    assign row_we = wr_en && (wr_idx == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (row_we) row_q <= wr_data;
    end
    assign words[g] = row_q;
  end

  always_comb begin
    valid_d = valid_q & ~clr_vec;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign valid = valid_q;
endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] words,
  input  logic [DEPTH-1:0]            valid,
  input  logic [WIDTH-1:0]            key,
  input  logic [WIDTH-1:0]            mask,
  output logic [DEPTH-1:0]            hit_vec
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (((words[g] ^ key) & ~mask) == '0);
  end
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  req,
  output logic [ADDR_W-1:0] first,
  output logic              any
);
  always_comb begin
    first = '1;
    any   = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        first = ADDR_W'(i);
        any   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_match_top.sv
module cam_match_top #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] idx,
  input  logic [WIDTH-1:0]  key,
  input  logic [WIDTH-1:0]  mask,
  input  logic              match_in_n,
  input  logic              full_in_n,
  output logic              match_n,
  output logic              multi_n,
  output logic              full_n,
  output logic [ADDR_W-1:0] hit_addr,
  output logic [ADDR_W-1:0] free_addr
);
  import cam_match_pkg::*;

  localparam logic [DEPTH-1:0] ONE_V = DEPTH'(1);

  logic                        rst_i_n;
  logic [DEPTH-1:0][WIDTH-1:0] words;
  logic [DEPTH-1:0]            valid;
  logic [DEPTH-1:0]            cmp_vec;
  logic [DEPTH-1:0]            hit_q;
  logic [DEPTH-1:0]            hit_d;
  logic                        hit_en;
  logic                        wr_en;
  logic [ADDR_W-1:0]           wr_idx;
  logic [DEPTH-1:0]            clr_vec;
  logic                        hit_any;
  logic                        free_any;
  logic                        loc_multi;
  logic                        loc_full;
  cam_op_e                     op_e;

  assign op_e = cam_op_e'(op);

  cam_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (key),
    .clr_vec (clr_vec),
    .words   (words),
    .valid   (valid)
  );

  cam_compare #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cmp (
    .words   (words),
    .valid   (valid),
    .key     (key),
    .mask    (mask),
    .hit_vec (cmp_vec)
  );

  cam_prio #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_hit_enc (
    .req   (hit_q),
    .first (hit_addr),
    .any   (hit_any)
  );

  cam_prio #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_free_enc (
    .req   (~valid),
    .first (free_addr),
    .any   (free_any)
  );

  assign loc_full = !free_any;

  // Store control: writes and invalidates, gated by device select
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = idx;
    clr_vec = '0;
    if (sel) begin
      unique case (op_e)
        OP_WR_IDX:  wr_en = 1'b1;
        OP_WR_FREE: begin
          wr_en  = !full_in_n && !loc_full;
          wr_idx = free_addr;
        end
        OP_CLR_IDX: clr_vec = ONE_V << idx;
        OP_CLR_HIT: clr_vec = cmp_vec;
        default: ;
      endcase
    end
  end

  // Match latch next state
  always_comb begin
    hit_en = 1'b0;
    hit_d  = hit_q;
    if (op_e == OP_CMP) begin
      hit_en = 1'b1;
      hit_d  = sel ? cmp_vec : '0;
    end else if (op_e == OP_ADV && sel) begin
      hit_en = 1'b1;
      hit_d  = hit_q & (hit_q - ONE_V);
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    hit_q <= '0;
    else if (hit_en) hit_q <= hit_d;
  end

  // Flags with cascade qualification
  assign loc_multi = |(hit_q & (hit_q - ONE_V));
  assign match_n   = match_in_n && !hit_any;
  assign multi_n   = match_in_n ? !loc_multi : !hit_any;
  assign full_n    = full_in_n || !loc_full;

  // R4
  multi_implies_match_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !multi_n |-> !match_n);

  // R8
  desel_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op == 3'd5 && !sel) |=> (hit_q == '0));

  // R7
  hold_hit_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op <= 3'd4) |=> $stable(hit_q));

  // R9
  advance_one_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op == 3'd6 && sel && hit_q != '0) |=>
      ($countones(hit_q) == $countones($past(hit_q)) - 1));

  // R11
  full_suppress_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op == 3'd2 && (&valid)) |=> $stable(valid));

  // R11
  free_slot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(&valid) |-> !valid[free_addr]);
endmodule

// File: tb/sim_cam_match_top.sv
module sim_cam_match_top;
  localparam int D = 16;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sel;
  logic [2:0]   op;
  logic [3:0]   idx;
  logic [W-1:0] key;
  logic [W-1:0] mask;
  logic         match_in_n;
  logic         full_in_n;
  logic         match_n, multi_n, full_n;
  logic [3:0]   hit_addr, free_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_word [D];
  logic [D-1:0] m_val;
  logic [D-1:0] m_hit;

  always #4 clk = ~clk;

  cam_match_top u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .op(op), .idx(idx), .key(key),
    .mask(mask), .match_in_n(match_in_n), .full_in_n(full_in_n),
    .match_n(match_n), .multi_n(multi_n), .full_n(full_n),
    .hit_addr(hit_addr), .free_addr(free_addr)
  );

  function automatic logic [D-1:0] ref_cmp(input logic [W-1:0] k, input logic [W-1:0] m);
    logic [D-1:0] v;
    for (int i = 0; i < D; i++)
      v[i] = m_val[i] && (((m_word[i] ^ k) & ~m) == '0);
    return v;
  endfunction

  function automatic logic [3:0] lowest(input logic [D-1:0] v);
    logic [3:0] r;
    r = 4'hF;
    for (int i = D - 1; i >= 0; i--) if (v[i]) r = 4'(i);
    return r;
  endfunction

  task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic check_all();
    int nh;
    nh = $countones(m_hit);
    chk("R3 match_n", W'(match_n), W'(match_in_n && nh == 0));
    chk("R4 multi_n", W'(multi_n), W'(match_in_n ? !(nh >= 2) : !(nh >= 1)));
    chk("R5 full_n", W'(full_n), W'(full_in_n || !(&m_val)));
    chk("R6 hit_addr", W'(hit_addr), W'(lowest(m_hit)));
    chk("R11 free_addr", W'(free_addr), W'(lowest(~m_val)));
  endtask

  // drive at a falling edge, one rising edge, check at the next falling edge
  task automatic do_op(input logic [2:0] o, input logic s, input logic [3:0] ix,
                       input logic [W-1:0] k, input logic [W-1:0] m);
    logic [D-1:0] cv;
    @(negedge clk);
    op = o; sel = s; idx = ix; key = k; mask = m;
    cv = ref_cmp(k, m);
    @(negedge clk);
    if (s) begin
      case (o)
        3'd1: begin m_word[ix] = k; m_val[ix] = 1'b1; end
        3'd2: if (!full_in_n && !(&m_val)) begin
                m_word[lowest(~m_val)] = k; m_val[lowest(~m_val)] = 1'b1;
              end
        3'd3: m_val[ix] = 1'b0;
        3'd4: m_val = m_val & ~cv;
        3'd5: m_hit = cv;
        3'd6: m_hit = m_hit & (m_hit - D'(1));
        default: ;
      endcase
    end else if (o == 3'd5) begin
      m_hit = '0;
    end
    op = 3'd0;
    check_all();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] ka, kb;
    logic [W-1:0] pool [4];
    void'($urandom(32'd2024));
    ka = 64'hDEAD_BEEF_0123_4567;
    kb = 64'h0F0F_1234_5555_AAAA;
    pool[0] = ka; pool[1] = ka ^ 64'h1; pool[2] = kb; pool[3] = kb ^ 64'h8000_0000_0000_0000;
    m_val = '0; m_hit = '0;
    for (int i = 0; i < D; i++) m_word[i] = '0;
    rst_n = 1'b0; sel = 1'b0; op = 3'd0; idx = '0; key = '0; mask = '0;
    match_in_n = 1'b1; full_in_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 match_n", W'(match_n), 64'd1);
    chk("R1 multi_n", W'(multi_n), 64'd1);
    chk("R1 full_n", W'(full_n), 64'd1);
    chk("R1 free_addr", W'(free_addr), 64'd0);
    chk("R1 hit_addr", W'(hit_addr), 64'hF);

    // R10 write by index, R2 exact compare
    do_op(3'd1, 1, 4'd3, ka, '0);
    do_op(3'd5, 1, 4'd0, ka, '0);
    chk("R2 single hit", W'(hit_addr), 64'd3);
    // R2 mask excludes bit 0: two hits
    do_op(3'd1, 1, 4'd7, ka ^ 64'h1, '0);
    do_op(3'd5, 1, 4'd0, ka, 64'h1);
    chk("R4 two hits multi", W'(multi_n), 64'd0);
    do_op(3'd5, 1, 4'd0, ka, '0);
    chk("R4 one hit no multi", W'(multi_n), 64'd1);
    // R4 cascade input low: one local hit gives multiple match
    match_in_n = 1'b0; #1;
    chk("R4 cascade multi", W'(multi_n), 64'd0);
    chk("R3 cascade match", W'(match_n), 64'd0);
    match_in_n = 1'b1;
    // R9 advance
    do_op(3'd5, 1, 4'd0, ka, 64'h1);
    do_op(3'd6, 1, 4'd0, '0, '0);
    chk("R9 next hit", W'(hit_addr), 64'd7);
    // R7 writes do not disturb the latch
    do_op(3'd1, 1, 4'd9, kb, '0);
    chk("R7 hold", W'(hit_addr), 64'd7);
    // R8 deselected compare clears
    do_op(3'd5, 0, 4'd0, ka, '0);
    chk("R8 cleared", W'(match_n), 64'd1);
    // R13 deselected write ignored
    do_op(3'd1, 0, 4'd12, kb ^ 64'h5, '0);
    do_op(3'd5, 1, 4'd0, kb ^ 64'h5, '0);
    chk("R13 no store", W'(match_n), 64'd1);
    // R12 invalidate by match
    do_op(3'd4, 1, 4'd0, ka, 64'h1);
    do_op(3'd5, 1, 4'd0, ka, 64'h1);
    chk("R12 gone", W'(match_n), 64'd1);
    // R11 fill via next free, then full
    full_in_n = 1'b1;
    do_op(3'd2, 1, 4'd0, kb ^ 64'h77, '0);
    chk("R11 suppressed by full_in_n", W'(free_addr), 64'd0);
    full_in_n = 1'b0;
    for (int i = 0; i < D; i++) do_op(3'd2, 1, 4'd0, W'(i) + 64'h100, '0);
    chk("R5 full", W'(full_n), 64'd0);
    full_in_n = 1'b1; #1;
    chk("R5 full_in high", W'(full_n), 64'd1);
    full_in_n = 1'b0;
    do_op(3'd2, 1, 4'd0, 64'h55, '0);
    do_op(3'd5, 1, 4'd0, 64'h55, '0);
    chk("R11 full write suppressed", W'(match_n), 64'd1);
    // R10 invalidate by index
    do_op(3'd3, 1, 4'd5, '0, '0);
    chk("R10 freed slot", W'(free_addr), 64'd5);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] o;
      logic [W-1:0] m;
      o = 3'($urandom_range(0, 6));
      case ($urandom_range(0, 3))
        0: m = '0;
        1: m = 64'h1;
        2: m = {$urandom, $urandom};
        default: m = 64'h8000_0000_0000_0001;
      endcase
      match_in_n = ($urandom_range(0, 4) != 0);
      full_in_n  = ($urandom_range(0, 4) == 0);
      do_op(o, ($urandom_range(0, 9) != 0), 4'($urandom_range(0, 15)),
            pool[$urandom_range(0, 3)], m);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule